// File: doc/BRIEF.md
# Register-Mapped CRC-16 Engine with Input Counter

The block is a CRC calculator placed on a 16-bit register port. Software writes data one byte per write to an input address. On each such write the engine folds the byte into a running 16-bit CRC and advances a consumed-input counter. The running result is read back from its own output address. The counter is read back from the low bits of the control address.

Writing the control address with its top bit set clears both the CRC state and the counter. That bit clears itself and always reads back as zero. A fixed four-byte known-answer sequence lets software confirm that the engine is sound before using it.

The CRC uses the reflected CCITT polynomial x^16+x^12+x^5+1, given as the constant 0x8408 in reflected form. The state starts at 0xFFFF. Each byte enters least-significant bit first. The output register presents the bitwise inverse of the state.

Top module: `crc16_regs`

## Requirements
- R1: After reset the control address (0) reads 0x0000 and the output address (2) reads 0x0000, because the inverse of the 0xFFFF start state is 0x0000.
- R2: A write to the control address with bit 15 set clears the CRC state to 0xFFFF and the counter to 0. Bit 15 reads back as 0 at all times.
- R3: A write to the control address with bit 15 clear has no effect on the counter or the result.
- R4: Each write to the input address (1) adds one to the counter, which is read in bits 11:0 of the control address. The counter saturates at 4095. Bits 15:12 of the control address read 0.
- R5: Each input write folds bits 7:0 of the write into the CRC. The fold uses reflected polynomial 0x8408, consumes the byte least-significant bit first, and the output reads the inverted state. Bits 15:12 are discarded at the port and bits 11:8 play no part in the result.
- R6: After a reset followed by inputs 0xCC, 0xF5, 0xF1, 0xA7, the counter reads 4 and the output reads 0x51DF.
- R7: A read of the output or control address in the cycle right after an input write already shows that write's effect.
- R8: Writes to the output address and reads of any address change nothing. Address 3 reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 input, 2 output, 3 unused |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data; valid in the same cycle as a read strobe |

## Verification
Write effects are registered at the clock edge that takes the write. Reads are combinational from those registers. So both the count and the result are due one cycle after the input write, and a read issued in that very next cycle must already see them. The bench drives every access at the falling edge. It samples read data half a cycle later, after the write's rising edge has passed. A reference model in the bench steps its CRC and count in the same cycle as the write. Each read is then compared with the model, including reads issued back-to-back after a write.

// File: rtl/crc16_regs.sv
module crc16_regs #(
  parameter int          DW       = 16,
  parameter int          AW       = 2,
  parameter int          CNT_W    = 12,
  parameter int          BYTE_W   = 8,
  parameter logic [15:0] POLY_REF = 16'h8408,
  parameter logic [15:0] START    = 16'hFFFF,
  parameter int          CLR_BIT  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_IN   = AW'(1);
  localparam logic [AW-1:0] A_OUT  = AW'(2);

  logic [15:0]      state;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] in_word;
  logic [15:0]      state_nxt;

  wire wr     = bus_sel && bus_we;
  wire wr_in  = wr && (bus_addr == A_IN);
  wire wr_clr = wr && (bus_addr == A_CTRL) && bus_wdata[CLR_BIT];

  assign in_word = bus_wdata[CNT_W-1:0];

  always_comb begin
    state_nxt = state ^ {8'h00, in_word[BYTE_W-1:0]};
    for (int k = 0; k < BYTE_W; k++)
      state_nxt = state_nxt[0] ? ((state_nxt >> 1) ^ POLY_REF) : (state_nxt >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= START;
      count <= '0;
    end else if (wr_clr) begin
      state <= START;
      count <= '0;
    end else if (wr_in) begin
      state <= state_nxt;
      if (count != {CNT_W{1'b1}}) count <= count + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {{(DW-CNT_W){1'b0}}, count};
        A_OUT:   bus_rdata = ~state;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (state == START && count == '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_in && count != {CNT_W{1'b1}}) |=> count == $past(count) + 1'b1);

  // R4
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_in && count == {CNT_W{1'b1}}) |=> count == {CNT_W{1'b1}});

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(state) && $stable(count)));

  // R3
  ctrl_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CTRL && !bus_wdata[CLR_BIT]) |=> ($stable(state) && $stable(count)));

  // R2
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == A_CTRL) |-> bus_rdata[DW-1:CNT_W] == '0);
endmodule

// File: tb/crc16_regs_test.sv
module crc16_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0;
  logic        bus_we = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_state;
  int          m_count;

  crc16_regs uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
                  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ b[i];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    if (a == 2'd0 && d[15]) begin m_state = 16'hFFFF; m_count = 0; end
    else if (a == 2'd1) begin
      m_state = ref_fold(m_state, d[7:0]);
      if (m_count < 4095) m_count++;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic check_both(input string req);
    logic [15:0] v;
    rd(2'd2, v); check(req, v, ~m_state);
    rd(2'd0, v); check(req, v, 16'(m_count));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    m_state = 16'hFFFF; m_count = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(2'd0, v); check("R1 ctrl after reset", v, 16'h0000);
    rd(2'd2, v); check("R1 out after reset", v, 16'h0000);

    wr(2'd1, 16'h00CC); wr(2'd1, 16'h00F5); wr(2'd1, 16'h00F1); wr(2'd1, 16'h00A7);
    rd(2'd0, v); check("R6 count", v, 16'd4);
    rd(2'd2, v); check("R6 result", v, 16'h51DF);

    wr(2'd0, 16'h8000);
    rd(2'd0, v); check("R2 count cleared, bit15 reads 0", v, 16'h0000);
    rd(2'd2, v); check("R2 result cleared", v, 16'h0000);

    wr(2'd1, 16'hF3CC); wr(2'd1, 16'h0AF5); wr(2'd1, 16'h55F1); wr(2'd1, 16'hFFA7);
    rd(2'd2, v); check("R5 upper bits ignored", v, 16'h51DF);

    wr(2'd0, 16'h7FFF);
    rd(2'd0, v); check("R3 ctrl write without clear", v, 16'd4);
    rd(2'd2, v); check("R3 result kept", v, 16'h51DF);

    wr(2'd2, 16'h1234); wr(2'd3, 16'hFFFF);
    rd(2'd2, v); check("R8 write to output ignored", v, 16'h51DF);
    rd(2'd3, v); check("R8 unused address reads 0", v, 16'h0000);
    rd(2'd0, v); check("R8 count kept", v, 16'd4);

    wr(2'd1, 16'h0042);
    rd(2'd2, v); check("R7 result next cycle", v, ~m_state);
    wr(2'd1, 16'h0099);
    rd(2'd0, v); check("R7 count next cycle", v, 16'(m_count));

    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 19);
      logic [15:0] d = 16'($urandom);
      if (sel == 0) wr(2'd0, d | 16'h8000);
      else if (sel == 1) wr(2'd0, d & 16'h7FFF);
      else if (sel == 2) wr(2'd2, d);
      else wr(2'd1, d);
      check_both("R5 random mix");
    end

    wr(2'd0, 16'h8000);
    for (int n = 0; n < 4100; n++) wr(2'd1, 16'($urandom));
    rd(2'd0, v); check("R4 saturation at 4095", v, 16'd4095);
    rd(2'd2, v); check("R5 result after long run", v, ~m_state);
    wr(2'd1, 16'h0001);
    rd(2'd0, v); check("R4 stays saturated", v, 16'd4095);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule